// File: doc/BRIEF.md
# JTAG TAP State Navigator

This block sits on the master side of a JTAG link and steers a target's test access port from wherever it is to a requested controller state. It keeps its own copy of the target's 16-state controller, picks each TMS bit from a per-state path mask, and after every issued clock advances that copy through the standard transition table. After reset it regards the target's state as unknown, and the first request that has to move the port starts with a forced reset walk.

Three requests are accepted while the block is idle. A navigation request moves to a target state. A wait request moves to a state and then holds it for a given number of clocks. A release request parks a port that has been used back in Idle. Each issued clock is a single-cycle `tckEn` pulse, preceded by one cycle in which the TMS bit is already valid. TDI stays low throughout and TDO is not read. `done` marks the end of every request, including requests that issue no clock at all.

Top module: `tap_nav_top`

## Requirements
- R1: After reset, `tckEn`, `done`, `err` and `tdi` are low, and the tracked state is unknown.
- R2: When the tracked state is unknown, a navigation or wait request first issues five clocks with TMS=1 and then one with TMS=0, which leaves the tracked state at Idle. The usual rules then continue from Idle.
- R3: States are encoded Reset=0, Idle=1, SelectDR=2, CaptureDR=3, ShiftDR=4, Exit1DR=5, PauseDR=6, Exit2DR=7, UpdateDR=8, SelectIR=9, CaptureIR=10, ShiftIR=11, Exit1IR=12, PauseIR=13, Exit2IR=14, UpdateIR=15. Each walking step drives bit [target] of the current state's 16-bit path mask as TMS, and TMS bits are issued in path order.
- R4: If the target equals the tracked state, the block issues one TMS=0 clock for Idle, ShiftDR, PauseDR, ShiftIR or PauseIR, and one TMS=1 clock for Reset. It issues no clock for any other state.
- R5: A walk stops after at most nine steps. If the target has not been reached by then, `err` rises and stays high until the next accepted request. Every reachable target is reached with `err` low.
- R6: `tdi` is low during every clock the block issues.
- R7: A wait request with count N first navigates to the wait state, unless the port is known to be there already. It then issues N clocks, with TMS=1 if the wait state is Reset and TMS=0 otherwise. N=0 adds no clock.
- R8: A release request issues five TMS=1 clocks and one TMS=0 clock, ending in Idle, when the tracked state is known. It issues nothing when the state is unknown.
- R9: Each TMS value is stable for at least one cycle before its `tckEn` pulse and through that pulse. `tckEn` is never high on two cycles in a row.
- R10: `done` is high for exactly one cycle at the end of each accepted request.
- R11: Requests that arrive while a request is in progress are ignored. When several requests arrive together at idle, release is taken over wait, and wait over navigation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Navigation request strobe |
| waitReq | input | 1 | Wait request strobe |
| releaseReq | input | 1 | Release request strobe |
| targetState | input | 4 | Target or wait state, encoded as in R3 |
| waitCycles | input | CNT_W | Number of hold clocks for a wait request |
| tckEn | output | 1 | One-cycle enable for one TCK clock |
| tms | output | 1 | TMS bit for the next or current clock |
| tdi | output | 1 | TDI, held low |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Walk did not reach its target within the step cap |

## Verification
The bench goes after the same-state rule in its three forms: a stable state, Reset, and a transient state that must produce zero clocks. A design that simply skipped equal targets, or always clocked them, would show the wrong pulse count. It also checks that the forced reset walk is followed by the Idle same-state clock, and that a wait at Reset holds TMS high. A release from the unknown state must be silent, while one from a known state must not be. A design that lost its tracked state after a release, or that accepted a request while busy, would then follow a different TMS path in the next navigation and be caught by its pulse count and bit pattern.

// File: rtl/tap_nav_pkg.sv
package tap_nav_pkg;

  typedef enum logic [3:0] {
    TAP_RESET    = 4'd0,  TAP_IDLE     = 4'd1,  TAP_SEL_DR  = 4'd2,  TAP_CAP_DR  = 4'd3,
    TAP_SH_DR    = 4'd4,  TAP_EX1_DR   = 4'd5,  TAP_PAUSE_DR = 4'd6, TAP_EX2_DR  = 4'd7,
    TAP_UPD_DR   = 4'd8,  TAP_SEL_IR   = 4'd9,  TAP_CAP_IR  = 4'd10, TAP_SH_IR   = 4'd11,
    TAP_EX1_IR   = 4'd12, TAP_PAUSE_IR = 4'd13, TAP_EX2_IR  = 4'd14, TAP_UPD_IR  = 4'd15
  } tap_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;
    logic forceReset;
    logic loadTms;
    logic tmsVal;
    logic pulse;
    logic incRst;
    logic incStep;
    logic decWait;
    logic setKnown;
    logic setErr;
  } dp_cmd_t;

  // datapath -> control status
  typedef struct packed {
    logic known;
    logic atTarget;
    logic curStable;
    logic curIsReset;
    logic rstDone;
    logic rstHigh;
    logic stepCap;
    logic waitZero;
    logic maskBit;
    logic targetIsReset;
  } dp_sts_t;

  function automatic tap_state_e tapNext(input tap_state_e s, input logic t);
    case (s)
      TAP_RESET:    return t ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:     return t ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR:   return t ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR:   return t ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:    return t ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR:   return t ? TAP_UPD_DR : TAP_PAUSE_DR;
      TAP_PAUSE_DR: return t ? TAP_EX2_DR : TAP_PAUSE_DR;
      TAP_EX2_DR:   return t ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR:   return t ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR:   return t ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR:   return t ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:    return t ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR:   return t ? TAP_UPD_IR : TAP_PAUSE_IR;
      TAP_PAUSE_IR: return t ? TAP_EX2_IR : TAP_PAUSE_IR;
      TAP_EX2_IR:   return t ? TAP_UPD_IR : TAP_SH_IR;
      default:      return t ? TAP_SEL_DR : TAP_IDLE;
    endcase
  endfunction

  // bit [target] is the TMS value for the next step toward target
  function automatic logic [15:0] pathMask(input tap_state_e s);
    case (s)
      TAP_RESET:    return 16'h0001;
      TAP_IDLE:     return 16'hFFFD;
      TAP_SEL_DR:   return 16'hFE01;
      TAP_CAP_DR:   return 16'hFFE7;
      TAP_SH_DR:    return 16'hFFEF;
      TAP_EX1_DR:   return 16'hFF0F;
      TAP_PAUSE_DR: return 16'hFFBF;
      TAP_EX2_DR:   return 16'hFFFF;
      TAP_UPD_DR:   return 16'hFEFD;
      TAP_SEL_IR:   return 16'h0001;
      TAP_CAP_IR:   return 16'hF3FF;
      TAP_SH_IR:    return 16'hF7FF;
      TAP_EX1_IR:   return 16'h87FF;
      TAP_PAUSE_IR: return 16'hDFFF;
      TAP_EX2_IR:   return 16'hFFFF;
      default:      return 16'h7FFD;
    endcase
  endfunction

  function automatic logic isStable(input tap_state_e s);
    return (s == TAP_IDLE) || (s == TAP_SH_DR) || (s == TAP_PAUSE_DR) ||
           (s == TAP_SH_IR) || (s == TAP_PAUSE_IR);
  endfunction

endpackage

// File: rtl/tap_nav_dp.sv
module tap_nav_dp
  import tap_nav_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_STEPS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  input  logic [3:0]       targetIn,
  input  logic [CNT_W-1:0] waitIn,
  output dp_sts_t          sts,
  output logic             tmsOut,
  output logic             errOut
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEPS);
  localparam logic [2:0] RST_HIGH_N = 3'd5;
  localparam logic [2:0] RST_LEN    = 3'd6;

  tap_state_e       curState;
  tap_state_e       targetQ;
  logic             known;
  logic [CNT_W-1:0] waitQ;
  logic [2:0]       rstCnt;
  logic [STEP_W-1:0] stepQ;
  logic             tmsQ;
  logic             errQ;
  logic [15:0]      curMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= TAP_RESET;
      targetQ  <= TAP_RESET;
      known    <= 1'b0;
      waitQ    <= '0;
      rstCnt   <= '0;
      stepQ    <= '0;
      tmsQ     <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (cmd.accept) begin
        targetQ <= tap_state_e'(targetIn);
        waitQ   <= waitIn;
        rstCnt  <= '0;
        stepQ   <= '0;
        errQ    <= 1'b0;
      end
      if (cmd.forceReset) curState <= TAP_RESET;
      if (cmd.pulse)      curState <= tapNext(curState, tmsQ);
      if (cmd.loadTms)    tmsQ     <= cmd.tmsVal;
      if (cmd.incRst)     rstCnt   <= rstCnt + 3'd1;
      if (cmd.incStep)    stepQ    <= stepQ + 1'b1;
      if (cmd.decWait)    waitQ    <= waitQ - 1'b1;
      if (cmd.setKnown)   known    <= 1'b1;
      if (cmd.setErr)     errQ     <= 1'b1;
    end
  end

  assign curMask = pathMask(curState);

  always_comb begin
    sts.known         = known;
    sts.atTarget      = (curState == targetQ);
    sts.curStable     = isStable(curState);
    sts.curIsReset    = (curState == TAP_RESET);
    sts.rstDone       = (rstCnt == RST_LEN);
    sts.rstHigh       = (rstCnt < RST_HIGH_N);
    sts.stepCap       = (stepQ == STEP_LIM);
    sts.waitZero      = (waitQ == '0);
    sts.maskBit       = curMask[targetQ];
    sts.targetIsReset = (targetQ == TAP_RESET);
  end

  assign tmsOut = tmsQ;
  assign errOut = errQ;

  // R5: the walk counter never runs past its cap
  a_r5_step_cap: assert property (@(posedge clk) disable iff (!rstN) stepQ <= STEP_LIM);
  // R2: the tracked state becomes known only once it sits in Idle
  a_r2_known_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(known) |-> curState == TAP_IDLE);

endmodule

// File: rtl/tap_nav_ctrl.sv
module tap_nav_ctrl
  import tap_nav_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    waitReq,
  input  logic    releaseReq,
  input  dp_sts_t sts,
  output dp_cmd_t cmd,
  output logic    tckEn,
  output logic    done
);
  typedef enum logic [2:0] {PH_IDLE, PH_DECIDE, PH_SETUP, PH_PULSE, PH_DONE} phase_e;
  typedef enum logic [2:0] {SQ_ENTRY, SQ_RESET, SQ_SAME, SQ_WALK, SQ_WAIT, SQ_END} seq_e;
  typedef enum logic [1:0] {OP_NAV, OP_WAIT, OP_REL} op_e;

  phase_e ph, phN;
  seq_e   seq, seqN;
  op_e    op, opN;
  seq_e   afterGoto;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph  <= PH_IDLE;
      seq <= SQ_ENTRY;
      op  <= OP_NAV;
    end else begin
      ph  <= phN;
      seq <= seqN;
      op  <= opN;
    end
  end

  assign afterGoto = (op == OP_WAIT) ? SQ_WAIT : SQ_END;

  always_comb begin
    cmd  = '0;
    phN  = ph;
    seqN = seq;
    opN  = op;
    case (ph)
      PH_IDLE: if (releaseReq || waitReq || startReq) begin
        cmd.accept = 1'b1;
        phN  = PH_DECIDE;
        seqN = SQ_ENTRY;
        opN  = releaseReq ? OP_REL : (waitReq ? OP_WAIT : OP_NAV);
      end
      PH_DECIDE: begin
        case (seq)
          SQ_ENTRY: begin
            if (!sts.known && op == OP_REL) seqN = SQ_END;
            else if (!sts.known || op == OP_REL) begin
              cmd.forceReset = 1'b1;
              seqN = SQ_RESET;
            end else if (op == OP_WAIT && sts.atTarget) seqN = SQ_WAIT;
            else seqN = SQ_SAME;
          end
          SQ_RESET: begin
            if (sts.rstDone) begin
              cmd.setKnown = 1'b1;
              seqN = (op == OP_REL) ? SQ_END : SQ_SAME;
            end else begin
              cmd.loadTms = 1'b1;
              cmd.tmsVal  = sts.rstHigh;
              cmd.incRst  = 1'b1;
              phN = PH_SETUP;
            end
          end
          SQ_SAME: begin
            if (sts.atTarget) begin
              seqN = afterGoto;
              if (sts.curStable || sts.curIsReset) begin
                cmd.loadTms = 1'b1;
                cmd.tmsVal  = sts.curIsReset;
                phN = PH_SETUP;
              end
            end else seqN = SQ_WALK;
          end
          SQ_WALK: begin
            if (sts.atTarget) seqN = afterGoto;
            else if (sts.stepCap) begin
              cmd.setErr = 1'b1;
              seqN = SQ_END;
            end else begin
              cmd.loadTms = 1'b1;
              cmd.tmsVal  = sts.maskBit;
              cmd.incStep = 1'b1;
              phN = PH_SETUP;
            end
          end
          SQ_WAIT: begin
            if (sts.waitZero) seqN = SQ_END;
            else begin
              cmd.loadTms = 1'b1;
              cmd.tmsVal  = sts.targetIsReset;
              cmd.decWait = 1'b1;
              phN = PH_SETUP;
            end
          end
          default: phN = PH_DONE;
        endcase
      end
      PH_SETUP: phN = PH_PULSE;
      PH_PULSE: begin
        cmd.pulse = 1'b1;
        phN = PH_DECIDE;
      end
      default: phN = PH_IDLE;
    endcase
  end

  assign tckEn = (ph == PH_PULSE);
  assign done  = (ph == PH_DONE);

  // R9: a clock enable is always followed by a gap cycle
  a_r9_pulse_gap: assert property (@(posedge clk) disable iff (!rstN) tckEn |=> !tckEn);
  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

endmodule

// File: rtl/tap_nav_top.sv
module tap_nav_top
  import tap_nav_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_STEPS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             waitReq,
  input  logic             releaseReq,
  input  logic [3:0]       targetState,
  input  logic [CNT_W-1:0] waitCycles,
  output logic             tckEn,
  output logic             tms,
  output logic             tdi,
  output logic             done,
  output logic             err
);
  dp_cmd_t cmd;
  dp_sts_t sts;

  tap_nav_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .waitReq(waitReq),
    .releaseReq(releaseReq), .sts(sts), .cmd(cmd), .tckEn(tckEn), .done(done)
  );

  tap_nav_dp #(.CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .targetIn(targetState), .waitIn(waitCycles),
    .sts(sts), .tmsOut(tms), .errOut(err)
  );

  assign tdi = 1'b0;

  // R9: the datapath's TMS bit does not move on the cycle the control pulses
  a_r9_tms_setup: assert property (@(posedge clk) disable iff (!rstN) tckEn |-> $stable(tms));

endmodule

// File: tb/sim_tap_nav_top.sv
module sim_tap_nav_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, waitReq = 1'b0, releaseReq = 1'b0;
  logic [3:0] targetState = '0;
  logic [CNT_W-1:0] waitCycles = '0;
  logic tckEn, tms, tdi, done, err;

  always #10 clk = ~clk;  // 50 MHz

  tap_nav_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .waitReq(waitReq),
    .releaseReq(releaseReq), .targetState(targetState), .waitCycles(waitCycles),
    .tckEn(tckEn), .tms(tms), .tdi(tdi), .done(done), .err(err)
  );

  // monitor: only this process writes these totals
  int pulseTot = 0, doneTot = 0, tdiBad = 0, setupBad = 0, adjBad = 0, doneWide = 0;
  logic [31:0] hist = '0;
  logic prevTms = 1'b0, prevTck = 1'b0, prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (tckEn) begin
        pulseTot++;
        hist = {hist[30:0], tms};
        if (tdi !== 1'b0) tdiBad++;
        if (tms !== prevTms) setupBad++;
        if (prevTck) adjBad++;
      end
      if (done) begin
        doneTot++;
        if (prevDone) doneWide++;
      end
    end
    prevTms  = tms;
    prevTck  = tckEn;
    prevDone = done;
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  localparam logic [2:0] K_NAV = 3'b001, K_WAIT = 3'b010, K_REL = 3'b100;

  // kind bits {release, wait, start}; poke raises a navigation strobe while busy
  task automatic runOp(input logic [2:0] kind, input logic [3:0] tgt, input int n,
                       input int expCnt, input logic [15:0] expBits, input bit poke,
                       input string tag);
    int p0, d0, k;
    @(negedge clk); #1;
    p0 = pulseTot; d0 = doneTot;
    startReq = kind[0]; waitReq = kind[1]; releaseReq = kind[2];
    targetState = tgt; waitCycles = CNT_W'(n);
    @(negedge clk);
    startReq = 1'b0; waitReq = 1'b0; releaseReq = 1'b0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      startReq = 1'b1; targetState = 4'd0;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(tag, "err", int'(err), 0);  // R5 reachable targets never flag
    @(negedge clk); #1;
    k = pulseTot - p0;
    check(tag, "pulse count", k, expCnt);
    check(tag, "done count", doneTot - d0, 1);
    if (k == expCnt) begin
      for (int i = 0; i < k; i++)
        check(tag, $sformatf("tms bit %0d", i), int'(hist[k-1-i]), int'(expBits[i]));
    end
  endtask

  // navigation vectors from unknown: {target, count, tms bits LSB = first clock}
  localparam logic [23:0] NAV_TAB [11] = '{
    {4'd1,  4'd7, 16'h001F},  // R2 reset walk, then R4 Idle clock
    {4'd4,  4'd3, 16'h0001},  // R3 Idle -> ShiftDR
    {4'd13, 4'd7, 16'h002F},  // R3 ShiftDR -> PauseIR
    {4'd13, 4'd1, 16'h0000},  // R4 stable same state
    {4'd8,  4'd6, 16'h0037},  // R3 PauseIR -> UpdateDR
    {4'd8,  4'd0, 16'h0000},  // R4 transient same state, no clock
    {4'd0,  4'd3, 16'h0007},  // R3 UpdateDR -> Reset
    {4'd0,  4'd1, 16'h0001},  // R4 Reset same state, TMS high
    {4'd10, 4'd4, 16'h0006},  // R3 Reset -> CaptureIR
    {4'd7,  4'd7, 16'h0057},  // R3 CaptureIR -> Exit2DR
    {4'd1,  4'd2, 16'h0001}   // R3 Exit2DR -> Idle
  };

  task automatic applyReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runAll();
    applyReset();
    @(negedge clk);
    check("R1", "tckEn", int'(tckEn), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "tdi", int'(tdi), 0);
    runOp(K_REL, 4'd0, 0, 0, 16'h0, 1'b0, "R8 release unknown");
    for (int v = 0; v < 11; v++)
      runOp(K_NAV, NAV_TAB[v][23:20], 0, int'(NAV_TAB[v][19:16]), NAV_TAB[v][15:0],
            1'b0, $sformatf("R3 vector %0d", v));
    runOp(K_WAIT, 4'd6, 3, 7, 16'h0005, 1'b0, "R7 wait PauseDR");
    runOp(K_WAIT, 4'd6, 2, 2, 16'h0000, 1'b0, "R7 wait already there");
    runOp(K_WAIT, 4'd0, 2, 7, 16'h007F, 1'b0, "R7 wait Reset");
    runOp(K_WAIT, 4'd0, 0, 0, 16'h0000, 1'b0, "R7 zero wait");
    runOp(K_REL, 4'd0, 0, 6, 16'h001F, 1'b0, "R8 release known");
    runOp(K_NAV, 4'd11, 0, 4, 16'h0003, 1'b0, "R8 ends Idle");
    runOp(K_NAV, 4'd4, 0, 5, 16'h0007, 1'b1, "R11 busy ignored");
    runOp(K_NAV, 4'd4, 0, 1, 16'h0000, 1'b0, "R11 state after busy");
    runOp(K_NAV | K_REL, 4'd1, 0, 6, 16'h001F, 1'b0, "R11 release priority");
    applyReset();
    runOp(K_WAIT, 4'd1, 2, 9, 16'h001F, 1'b0, "R2 wait from unknown");
    check("R6", "tdi during clocks", tdiBad, 0);
    check("R9", "tms setup", setupBad, 0);
    check("R9", "adjacent pulses", adjBad, 0);
    check("R10", "wide done", doneWide, 0);
  endtask

  initial begin
    fork
      begin runAll(); finished = 1'b1; end
      begin repeat (100000) @(posedge clk); end
    join_any
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule